// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers 8-bit characters from an asynchronous serial line. The line is sampled once per pulse of a baud enable that runs at sixteen times the bit rate. While the receiver is idle, a low sample starts a candidate frame. The line is then checked again near the middle of that start bit. If the line has gone high again, the event is treated as noise and dropped. Otherwise the receiver samples eight data bits, least significant first, once per bit period at mid-bit, and then checks a single stop bit.

At the stop-bit sample, the shifted character moves into a holding register that the host reads. A four-bit line-status word flags the result: a character is waiting, an unread character was overwritten, the stop bit was bad, or a break was seen. One host read pulse takes the character and clears every status flag. After a bad stop bit, the receiver stays disarmed until the line returns high, so a line held low yields a single break character.

Top module: `async_rx`

## Requirements
- R1: After reset, `lineStat` is 4'b0000 and `rxByte` is 8'h00.
- R2: A frame is one low start bit, then eight data bits least significant first, then one stop bit, each bit lasting 16 ticks. After the stop bit is sampled, the byte appears on `rxByte` and `lineStat[0]` (data ready) is 1.
- R3: A low pulse on `serIn` that is high again before the middle of the start bit produces no character and sets no status flag. A correct frame that follows is still received.
- R4: A `hostRd` pulse in a cycle with no new transfer clears all four `lineStat` bits by the next cycle.
- R5: A transfer into the holding register while `lineStat[0]` is 1 and no read is in progress sets `lineStat[1]` (overrun). `rxByte` then shows the newer byte.
- R6: A stop bit sampled as 0 sets `lineStat[2]` (framing error), and the byte is still delivered with `lineStat[0]` set.
- R7: A framing error whose eight data bits are all 0 also sets `lineStat[3]` (break). `lineStat[3]` is never 1 while `lineStat[2]` is 0.
- R8: The error bits `lineStat[3:1]` stay set across further transfers until a host read.
- R9: `rxByte` changes only on a transfer. A host read leaves it unchanged.
- R10: After a bad stop bit, the receiver does not look for a new start bit until `serIn` has been seen high. A line held low past the stop bit yields exactly one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| serIn | input | 1 | Serial receive line, idles high |
| hostRd | input | 1 | Host read pulse, takes the byte and clears status |
| rxByte | output | 8 | Receive holding register |
| lineStat | output | 4 | {break, framing error, overrun, data ready} |

## Verification
Characters 8'h55, 8'hA3, 8'h01, 8'h80, 8'hFF and 8'h00 are sent with good stop bits. Alternating bits, single end bits and the all-ones and all-zeros patterns tell a correct bit order and correct mid-bit sampling apart from a shifted, reversed or stuck path. A short low glitch separates a receiver that validates the start bit from one that starts on any edge. Frames with a low stop bit, with zero and nonzero data, separate the framing flag from the break flag. A stop bit held low well past its slot shows whether the receiver waits for the line to go high before it re-arms. Two back-to-back frames with no read in between expose the overrun flag and show which byte is kept.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAITHI
  } rxState_e;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } rxStrobe_t;

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      lineIn,
  output rxStrobe_t strb
);

  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int IDX_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int MID_CNT  = OVERSAMPLE / 2 - 2;
  localparam int LAST_CNT = OVERSAMPLE - 1;

  rxState_e         state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [IDX_W-1:0] bitIdx, idxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      bitIdx <= idxNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    idxNext   = bitIdx;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (tick16 && !lineIn) begin
          stateNext = ST_START;
          cntNext   = '0;
        end
      end
      ST_START: begin
        if (tick16) begin
          if (cnt == CNT_W'(MID_CNT)) begin
            cntNext = '0;
            idxNext = '0;
            stateNext = lineIn ? ST_IDLE : ST_DATA;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick16) begin
          if (cnt == CNT_W'(LAST_CNT)) begin
            strb.shiftEn = 1'b1;
            cntNext      = '0;
            if (bitIdx == IDX_W'(DATA_BITS - 1)) stateNext = ST_STOP;
            else                                 idxNext   = bitIdx + 1'b1;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick16) begin
          if (cnt == CNT_W'(LAST_CNT)) begin
            strb.loadEn = 1'b1;
            cntNext     = '0;
            stateNext   = lineIn ? ST_IDLE : ST_WAITHI;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      ST_WAITHI: begin
        if (lineIn) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 hostRd,
  input  rxStrobe_t            strb,
  output logic                 lineOut,
  output logic [DATA_BITS-1:0] rxByte,
  output logic [3:0]           lineStat
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_BITS-1:0]   shReg;
  logic [DATA_BITS-1:0]   holdReg;
  logic                   ready, ovr, fe, brk;
  logic                   stopBad;

  assign lineOut = syncReg[SYNC_STAGES-1];
  assign stopBad = ~lineOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], serIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (strb.shiftEn) shReg <= {lineOut, shReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      ready   <= 1'b0;
      ovr     <= 1'b0;
      fe      <= 1'b0;
      brk     <= 1'b0;
    end else if (strb.loadEn) begin
      holdReg <= shReg;
      ready   <= 1'b1;
      ovr     <= (ready | ovr) & ~hostRd;
      fe      <= (fe & ~hostRd) | stopBad;
      brk     <= (brk & ~hostRd) | (stopBad & (shReg == '0));
    end else if (hostRd) begin
      ready <= 1'b0;
      ovr   <= 1'b0;
      fe    <= 1'b0;
      brk   <= 1'b0;
    end
  end

  assign rxByte   = holdReg;
  assign lineStat = {brk, fe, ovr, ready};

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick16,
  input  logic                 serIn,
  input  logic                 hostRd,
  output logic [DATA_BITS-1:0] rxByte,
  output logic [3:0]           lineStat
);

  rxStrobe_t strb;
  logic      lineSync;

  async_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .tick16(tick16),
    .lineIn(lineSync),
    .strb  (strb)
  );

  async_rx_dp #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .hostRd  (hostRd),
    .strb    (strb),
    .lineOut (lineSync),
    .rxByte  (rxByte),
    .lineStat(lineStat)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostRd,
  input logic                 loadEn,
  input logic                 shiftEn,
  input logic [DATA_BITS-1:0] rxByte,
  input logic [3:0]           lineStat
);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !loadEn) |=> (lineStat == 4'b0000)); // R4

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineStat[1]) |-> $past(lineStat[0])); // R5

  AST_BRK_NEEDS_FE: assert property (@(posedge clk) disable iff (!rstN)
    lineStat[3] |-> lineStat[2]); // R7

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(rxByte)); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shiftEn, loadEn})); // R2

  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> lineStat[0]); // R2

endmodule

bind async_rx async_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .hostRd  (hostRd),
  .loadEn  (strb.loadEn),
  .shiftEn (strb.shiftEn),
  .rxByte  (rxByte),
  .lineStat(lineStat)
);

// File: tb/async_rx_tb_top.sv
module async_rx_tb_top;

  localparam int DIV      = 4;
  localparam int BIT_CLKS = DIV * 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       serIn = 1'b1;
  logic       hostRd = 1'b0;
  logic [7:0] rxByte;
  logic [3:0] lineStat;

  int  nTests = 0;
  int  nFails = 0;
  bit  autoRead = 1'b1;
  logic [9:0] expQ[$];   // {brk, fe, byte}

  always #4 clk = ~clk;

  async_rx dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick16  (tick16),
    .serIn   (serIn),
    .hostRd  (hostRd),
    .rxByte  (rxByte),
    .lineStat(lineStat)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc     = (tc == DIV - 1) ? 0 : tc + 1;
      tick16 = (tc == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic b, input int clks);
    serIn = b;
    repeat (clks) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic stopVal, input bit push);
    if (push) expQ.push_back({~stopVal & (d == 8'h00), ~stopVal, d});
    driveBit(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) driveBit(d[i], BIT_CLKS);
    driveBit(stopVal, BIT_CLKS);
    driveBit(1'b1, 2 * BIT_CLKS);
  endtask

  // scoreboard monitor
  initial begin
    logic [9:0] e;
    forever begin
      @(negedge clk);
      if (rstN && autoRead && lineStat[0]) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected byte", {24'h0, rxByte}, 0);
        end else begin
          e = expQ.pop_front();
          check(rxByte == e[7:0], "R2 byte", rxByte, e[7:0]);
          check(lineStat == {e[9], e[8], 1'b0, 1'b1}, "R6/R7 status", lineStat,
                {e[9], e[8], 1'b0, 1'b1});
        end
        hostRd = 1'b1;
        @(negedge clk);
        hostRd = 1'b0;
        check(lineStat == 4'b0000, "R4 read clears", lineStat, 0);
        check(rxByte == e[7:0], "R9 byte kept after read", rxByte, e[7:0]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(lineStat == 4'b0000, "R1 status", lineStat, 0);
    check(rxByte == 8'h00, "R1 byte", rxByte, 0);
    rstN = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R2: several bit patterns
    sendFrame(8'h55, 1'b1, 1'b1);
    sendFrame(8'hA3, 1'b1, 1'b1);
    sendFrame(8'h01, 1'b1, 1'b1);
    sendFrame(8'h80, 1'b1, 1'b1);
    sendFrame(8'hFF, 1'b1, 1'b1);
    sendFrame(8'h00, 1'b1, 1'b1);

    // R3: glitch of 3 ticks, then a good frame
    driveBit(1'b0, 3 * DIV);
    driveBit(1'b1, 2 * BIT_CLKS);
    check(lineStat == 4'b0000, "R3 glitch ignored", lineStat, 0);
    sendFrame(8'h3C, 1'b1, 1'b1);

    // R6 framing error, R7 break
    sendFrame(8'h5A, 1'b0, 1'b1);
    sendFrame(8'h00, 1'b0, 1'b1);

    // R10: stop held low well past its slot gives one character
    expQ.push_back({1'b1, 1'b1, 8'h00});
    driveBit(1'b0, 10 * BIT_CLKS + 3 * BIT_CLKS);
    driveBit(1'b1, 2 * BIT_CLKS);
    check(expQ.size() == 0, "R10 one break char", expQ.size(), 0);
    check(lineStat == 4'b0000, "R10 no rearm while low", lineStat, 0);
    sendFrame(8'hC7, 1'b1, 1'b1);

    // R5 overrun and R8 sticky errors, read by hand
    autoRead = 1'b0;
    @(negedge clk);
    sendFrame(8'h12, 1'b0, 1'b0);
    check(lineStat == 4'b0101, "R6 framing before overrun", lineStat, 4'h5);
    sendFrame(8'h34, 1'b1, 1'b0);
    check(rxByte == 8'h34, "R5 newer byte kept", rxByte, 8'h34);
    check(lineStat == 4'b0111, "R5/R8 overrun, sticky framing", lineStat, 4'h7);
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    check(lineStat == 4'b0000, "R4/R8 read clears errors", lineStat, 0);
    check(rxByte == 8'h34, "R9 byte kept", rxByte, 8'h34);
    autoRead = 1'b1;

    sendFrame(8'h96, 1'b1, 1'b1);
    repeat (BIT_CLKS) @(negedge clk);
    check(expQ.size() == 0, "R2 all bytes seen", expQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule